// File: doc/BRIEF.md
# Two-Wire Bus Start/Stop Condition Monitor

This block listens passively to the clock and data lines of a two-wire serial bus and reports when a transfer begins or ends. Both lines are brought into the system clock domain through a short chain of flip-flops. The block then compares each synchronised sample with the one before it. A falling data line while the clock line stays high marks the start of a transfer. A rising data line while the clock line stays high marks its end. From these two conditions the block keeps a busy flag for the bus. It also gives a one-cycle pulse when a new start arrives while a transfer is still open.

Each condition sets its own sticky status bit, and the bit stays set until software clears it. A two-bit enable mask chooses which status bits appear in the masked status. Any enabled bit that is set drives the single interrupt line. The block drives neither line, so it can sit on any bus as an observer. A slave controller can also use it to learn when transfers begin and end.

Top module: `i2c_cond_monitor`

## Requirements
- R1: When the data line goes from 1 to 0 and the clock line reads 1 on both samples, raw status bit 0 (start) is set.
- R2: When the data line goes from 0 to 1 and the clock line reads 1 on both samples, raw status bit 1 (stop) is set.
- R3: `bus_busy` becomes 1 on a detected start and 0 on a detected stop. A stop seen while the bus is free leaves it at 0.
- R4: A start detected while `bus_busy` is already 1 produces a one-cycle pulse on `restart`, sets raw bit 0 and keeps `bus_busy` at 1. A start on a free bus gives no pulse.
- R5: No other single-line change creates a condition. This covers a data change while the clock line is low, and any change of the clock line itself.
- R6: Raw status bits are sticky. On a cycle with `clr_wr` high, each bit of `clr_bits` that is 1 clears the raw bit at the same position (bit 0 start, bit 1 stop). Bits written as 0 are left alone.
- R7: If a clear and a new event for the same bit fall on the same clock edge, that bit ends up set.
- R8: `masked_status` equals the raw status ANDed with `intr_mask`, and `irq` is 1 exactly when some masked bit is 1.
- R9: On a cycle with `mask_wr` high, `intr_mask` takes the value of `mask_bits` at the next edge.
- R10: With the reset held, the raw status, mask, busy flag, `restart` and `irq` are all 0, and both synchronised lines read as idle (high).
- R11: A line change applied between clock edges shows up in the raw status on the third rising edge after it, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as observed (asynchronous) |
| sda_i | input | 1 | Serial data line as observed (asynchronous) |
| clr_wr | input | 1 | Strobe for the write-one-to-clear status write |
| clr_bits | input | 2 | Clear pattern: bit 0 start, bit 1 stop |
| mask_wr | input | 1 | Strobe that loads the interrupt enable mask |
| mask_bits | input | 2 | New mask value: bit 0 start, bit 1 stop |
| raw_status | output | 2 | Sticky event bits: bit 0 start, bit 1 stop |
| intr_mask | output | 2 | Current interrupt enable mask |
| masked_status | output | 2 | Raw status gated by the mask |
| irq | output | 1 | High when any masked status bit is set |
| bus_busy | output | 1 | High between a detected start and the next stop |
| restart | output | 1 | One-cycle pulse on a repeated start |

## Verification
The assertions check, on every cycle, how internal condition events relate to the registered state. Each event must land in its raw bit and move the busy flag. A raw bit must survive any cycle that does not clear it. A requested clear must take effect unless an event lands on the same edge. An enabled event must raise the interrupt. Only the bench scenarios can show the path from the pins. That path covers the exact three-edge latency through the synchronisers, the fact that transitions with the clock line low or with the clock line itself moving are ignored, the repeated-start pulse, and the way a clear and an event combine when they meet on one edge.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    localparam int EVT_W     = 2;
    localparam int EVT_START = 0;
    localparam int EVT_STOP  = 1;

    // Sampled bus lines; packed order scl=bit1, sda=bit0
    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    // Condition events; packed order stop=bit1, start=bit0 (matches status bits)
    typedef struct packed {
        logic stop;
        logic start;
    } cond_evt_t;

    localparam line_t LINE_IDLE = '{scl: 1'b1, sda: 1'b1};

    // A condition needs the clock line high on both samples
    function automatic cond_evt_t classify(line_t prev, line_t cur);
        cond_evt_t e;
        logic      clk_hi;
        clk_hi  = prev.scl & cur.scl;
        e.start = clk_hi &  prev.sda & ~cur.sda;
        e.stop  = clk_hi & ~prev.sda &  cur.sda;
        return e;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int          STAGES    = 2,
    parameter int          W         = 2,
    parameter logic [W-1:0] RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RESET_VAL;
                    else     chain[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RESET_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_cond_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_t     line_cur,
    output cond_evt_t evt,
    output logic      busy,
    output logic      rep_start
);

    line_t line_prev;

    always_ff @(posedge clk) begin
        if (rst) line_prev <= LINE_IDLE;
        else     line_prev <= line_cur;
    end

    assign evt = classify(line_prev, line_cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            rep_start <= 1'b0;
        end else begin
            rep_start <= evt.start & busy;
            if (evt.start)     busy <= 1'b1;
            else if (evt.stop) busy <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_cond_status.sv
module i2c_cond_status
    import i2c_cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cond_evt_t        evt,
    input  logic             clr_wr,
    input  logic [EVT_W-1:0] clr_bits,
    input  logic             mask_wr,
    input  logic [EVT_W-1:0] mask_bits,
    output logic [EVT_W-1:0] raw_q,
    output logic [EVT_W-1:0] mask_q,
    output logic [EVT_W-1:0] masked,
    output logic             irq
);

    logic [EVT_W-1:0] evt_vec;
    logic [EVT_W-1:0] clr_vec;

    assign evt_vec = evt;
    assign clr_vec = clr_wr ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_vec) | evt_vec;
            if (mask_wr) mask_q <= mask_bits;
        end
    end

    assign masked = raw_q & mask_q;
    assign irq    = |masked;

endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor
    import i2c_cond_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             clr_wr,
    input  logic [EVT_W-1:0] clr_bits,
    input  logic             mask_wr,
    input  logic [EVT_W-1:0] mask_bits,
    output logic [EVT_W-1:0] raw_status,
    output logic [EVT_W-1:0] intr_mask,
    output logic [EVT_W-1:0] masked_status,
    output logic             irq,
    output logic             bus_busy,
    output logic             restart
);

    localparam int LINE_W = $bits(line_t);

    line_t     line_sync;
    cond_evt_t evt_w;

    i2c_line_sync #(
        .STAGES    (SYNC_STAGES),
        .W         (LINE_W),
        .RESET_VAL (LINE_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({scl_i, sda_i}),
        .sync_o  (line_sync)
    );

    i2c_cond_detect u_detect (
        .clk       (clk),
        .rst       (rst),
        .line_cur  (line_sync),
        .evt       (evt_w),
        .busy      (bus_busy),
        .rep_start (restart)
    );

    i2c_cond_status u_status (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt_w),
        .clr_wr    (clr_wr),
        .clr_bits  (clr_bits),
        .mask_wr   (mask_wr),
        .mask_bits (mask_bits),
        .raw_q     (raw_status),
        .mask_q    (intr_mask),
        .masked    (masked_status),
        .irq       (irq)
    );

endmodule

// File: rtl/i2c_cond_monitor_chk.sv
module i2c_cond_monitor_chk
    import i2c_cond_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input cond_evt_t        evt,
    input logic             clr_wr,
    input logic [EVT_W-1:0] clr_bits,
    input logic             mask_wr,
    input logic [EVT_W-1:0] raw_status,
    input logic [EVT_W-1:0] intr_mask,
    input logic             irq,
    input logic             bus_busy,
    input logic             restart
);

    assert_evt_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(evt.start && evt.stop));

    assert_start_raw_R1: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> raw_status[EVT_START]);

    assert_stop_raw_R2: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> raw_status[EVT_STOP]);

    assert_busy_set_R3: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> bus_busy);

    assert_busy_clr_R3: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !bus_busy);

    assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
        (evt.start && bus_busy) |=> (restart && bus_busy));

    assert_no_restart_R4: assert property (@(posedge clk) disable iff (rst)
        !evt.start |=> !restart);

    assert_start_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (raw_status[EVT_START] && !(clr_wr && clr_bits[EVT_START])) |=> raw_status[EVT_START]);

    assert_stop_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (raw_status[EVT_STOP] && !(clr_wr && clr_bits[EVT_STOP])) |=> raw_status[EVT_STOP]);

    assert_start_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_bits[EVT_START] && !evt.start) |=> !raw_status[EVT_START]);

    assert_clear_vs_event_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_bits[EVT_STOP] && evt.stop) |=> raw_status[EVT_STOP]);

    assert_irq_on_event_R8: assert property (@(posedge clk) disable iff (rst)
        (evt.start && intr_mask[EVT_START] && !mask_wr) |=> irq);

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(intr_mask));

endmodule

bind i2c_cond_monitor i2c_cond_monitor_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt_w),
    .clr_wr     (clr_wr),
    .clr_bits   (clr_bits),
    .mask_wr    (mask_wr),
    .raw_status (raw_status),
    .intr_mask  (intr_mask),
    .irq        (irq),
    .bus_busy   (bus_busy),
    .restart    (restart)
);

// File: tb/i2c_cond_monitor_bench.sv
`timescale 1ns/1ps
module i2c_cond_monitor_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_i = 1'b1;
    logic       sda_i = 1'b1;
    logic       clr_wr = 1'b0;
    logic [1:0] clr_bits = 2'b00;
    logic       mask_wr = 1'b0;
    logic [1:0] mask_bits = 2'b00;
    logic [1:0] raw_status;
    logic [1:0] intr_mask;
    logic [1:0] masked_status;
    logic       irq;
    logic       bus_busy;
    logic       restart;

    int n_checks = 0;
    int n_fail   = 0;

    logic [1:0] m_raw  = 2'b00;
    logic [1:0] m_mask = 2'b00;
    logic       m_busy = 1'b0;

    always #5 clk = ~clk;

    i2c_cond_monitor u_i2c_cond_monitor (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl_i),
        .sda_i         (sda_i),
        .clr_wr        (clr_wr),
        .clr_bits      (clr_bits),
        .mask_wr       (mask_wr),
        .mask_bits     (mask_bits),
        .raw_status    (raw_status),
        .intr_mask     (intr_mask),
        .masked_status (masked_status),
        .irq           (irq),
        .bus_busy      (bus_busy),
        .restart       (restart)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(req, {30'd0, raw_status}, {30'd0, m_raw});
        check("R8", {30'd0, masked_status}, {30'd0, m_raw & m_mask});
        check("R8", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
        check("R3", {31'd0, bus_busy}, {31'd0, m_busy});
    endtask

    // Drive one line change; optionally clear all bits on the edge the event lands
    task automatic step(input logic nscl, input logic nsda, input logic clr_mid);
        logic  s, p, rep;
        string tag;
        s   = scl_i & nscl &  sda_i & ~nsda;
        p   = scl_i & nscl & ~sda_i &  nsda;
        rep = s & m_busy;
        tag = s ? "R1" : (p ? "R2" : "R5");
        @(negedge clk);
        scl_i = nscl;
        sda_i = nsda;
        @(posedge clk);
        @(posedge clk);
        #2;
        check("R11", {30'd0, raw_status}, {30'd0, m_raw});
        if (clr_mid) begin
            clr_wr   = 1'b1;
            clr_bits = 2'b11;
        end
        @(posedge clk);
        #2;
        clr_wr   = 1'b0;
        clr_bits = 2'b00;
        m_raw = (clr_mid ? 2'b00 : m_raw) | {p, s};
        if (s)      m_busy = 1'b1;
        else if (p) m_busy = 1'b0;
        check(clr_mid ? "R7" : tag, {30'd0, raw_status}, {30'd0, m_raw});
        check_outputs(tag);
        check("R4", {31'd0, restart}, {31'd0, rep});
        @(posedge clk);
        #2;
        check("R4", {31'd0, restart}, 32'd0);
    endtask

    task automatic write_mask(input logic [1:0] m);
        @(negedge clk);
        mask_wr   = 1'b1;
        mask_bits = m;
        @(posedge clk);
        #2;
        mask_wr = 1'b0;
        m_mask  = m;
        check("R9", {30'd0, intr_mask}, {30'd0, m});
        check_outputs("R8");
    endtask

    task automatic write_clear(input logic [1:0] c);
        @(negedge clk);
        clr_wr   = 1'b1;
        clr_bits = c;
        @(posedge clk);
        #2;
        clr_wr   = 1'b0;
        clr_bits = 2'b00;
        m_raw = m_raw & ~c;
        check_outputs("R6");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R10", {30'd0, raw_status}, 32'd0);
        check("R10", {30'd0, intr_mask}, 32'd0);
        check("R10", {29'd0, irq, bus_busy, restart}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int m = 0; m < 4; m++) begin
            write_mask(m[1:0]);
            // forward walk: start, then ignored moves
            step(1'b1, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0);
            step(1'b0, 1'b1, 1'b0);
            step(1'b1, 1'b1, 1'b0);
            // repeated start while busy
            step(1'b1, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0);
            step(1'b1, 1'b0, 1'b0);
            // stop, with clear meeting the event on odd masks
            step(1'b1, 1'b1, m[0]);
            // reverse walk: ignored moves, then stop on a free bus
            step(1'b0, 1'b1, 1'b0);
            step(1'b0, 1'b0, 1'b0);
            step(1'b1, 1'b0, 1'b0);
            write_clear(2'b01);
            step(1'b1, 1'b1, 1'b0);
            write_clear(2'b01);
            write_clear(2'b10);
            write_clear(2'b11);
            check("R6", {30'd0, raw_status}, 32'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule